// File: doc/BRIEF.md
# Virtual Channel Frame Integrity Monitor

This block watches a stream of already-decoded packet events from a camera serial receiver and keeps frame bookkeeping separately for each of four virtual channels. Every event carries a kind (frame start, frame end, long packet or other short packet), a channel number, a 6-bit data type, a 16-bit word count and a flag saying the packet failed its CRC. Header decoding and CRC computation happen upstream. Only the event summary arrives here.

For each channel the block pairs frame starts with frame ends and reports two kinds of error. A sync error means the pairing broke. A data error means a frame closed after a corrupted long packet arrived inside it. Every frame end also gives a frame-received pulse. Each channel keeps two information words: a line count with the byte count of the latest long packet, and the data type of the latest packet. A register read port selects one channel's words.

A per-channel enable mask lets system software leave some channels out. The pulses feed an interrupt status block, and the information words feed a register read path.

Top module: `vc_frame_monitor`

## Requirements
- R1: The four channels are independent. An event with channel number `evt_vc` changes only that channel's state and pulses, and the pulse vectors carry bit v for channel v.
- R2: A frame end (`evt_kind` = 1) on a channel with no open frame gives a one-cycle `sync_err` pulse for that channel.
- R3: A frame start (`evt_kind` = 0) on a channel whose frame is already open gives a `sync_err` pulse. The frame stays open, and its line count and CRC history restart.
- R4: A frame end on an open frame gives a `data_err` pulse when a long packet (`evt_kind` = 2) with `evt_crc_err` = 1 arrived on that channel since the frame start. CRC errors on long packets outside an open frame are not counted. The CRC history clears at every frame start and frame end.
- R5: Every accepted frame end gives a `frame_rcvd` pulse for its channel, whether or not it pairs.
- R6: Info word 1 (`rd_info1`) holds the line count in bits 31:16 and the word count of the channel's latest long packet in bits 15:0.
- R7: Info word 2 (`rd_info2`) holds the data type of the channel's latest accepted event of any kind (including short packets, `evt_kind` = 3) in bits 5:0. Bits 31:6 are zero.
- R8: The line count goes to zero on a frame start and rises by one on each long packet of that channel, wrapping from 65535 to 0.
- R9: An event for a channel whose `vc_enable` bit is 0 changes nothing: no pulse and no change to the information words.
- R10: The pulses appear in the cycle after the clock edge that samples the event and last one cycle. With no valid event, every pulse is low. `rd_info1`/`rd_info2` show the channel selected by `rd_vc` one cycle after the edge that samples `rd_vc`.
- R11: Synchronous reset clears all pulses, all information words, and every channel's open-frame and CRC state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_enable | input | 4 | Per-channel enable mask, bit v for channel v |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 2 | 0 frame start, 1 frame end, 2 long packet, 3 other short packet |
| evt_vc | input | 2 | Virtual channel of the event |
| evt_dt | input | 6 | Data type of the event |
| evt_wc | input | 16 | Word count (byte count) of a long packet |
| evt_crc_err | input | 1 | Long packet failed its CRC |
| rd_vc | input | 2 | Channel selected for the info read port |
| sync_err | output | 4 | Frame-pairing error pulses, one per channel |
| data_err | output | 4 | Corrupted-frame pulses at frame end, one per channel |
| frame_rcvd | output | 4 | Frame-end pulses, one per channel |
| rd_info1 | output | 32 | Line count and latest long packet byte count |
| rd_info2 | output | 32 | Latest data type |

## Verification
The bench targets these cases:
- A frame end with no open frame and a repeated frame start. A design that ignored either would stay silent or leave a stale line count behind the second start.
- A CRC failure before the frame start, and one in an earlier frame. A design that kept the CRC flag across frames, or counted failures outside a frame, would report a clean frame as corrupted.
- Events on a masked channel, checked through the read port afterwards. A design that updated state before applying the mask would show changed byte counts or data types there.
- Interleaved frames on several channels, and a line count driven past 65535. These catch shared state between channels and wrong counter widths.

// File: rtl/vcfm_pkg.sv
package vcfm_pkg;
  typedef enum logic [1:0] {
    EVT_FS    = 2'd0,
    EVT_FE    = 2'd1,
    EVT_LONG  = 2'd2,
    EVT_SHORT = 2'd3
  } evt_kind_e;
endpackage

// File: rtl/vcfm_channel.sv
module vcfm_channel
  import vcfm_pkg::*;
#(
  parameter int DT_W   = 6,
  parameter int WC_W   = 16,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  evt_kind_e         kind,
  input  logic [DT_W-1:0]   dt,
  input  logic [WC_W-1:0]   wc,
  input  logic              crc_err,
  output logic              sync_err_o,
  output logic              data_err_o,
  output logic              frame_rcvd_o,
  output logic [LINE_W-1:0] line_o,
  output logic [WC_W-1:0]   bytes_o,
  output logic [DT_W-1:0]   dt_o
);
  logic frame_open_q;
  logic crc_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_open_q <= 1'b0;
      crc_seen_q   <= 1'b0;
      sync_err_o   <= 1'b0;
      data_err_o   <= 1'b0;
      frame_rcvd_o <= 1'b0;
      line_o       <= '0;
      bytes_o      <= '0;
      dt_o         <= '0;
    end else begin
      sync_err_o   <= 1'b0;
      data_err_o   <= 1'b0;
      frame_rcvd_o <= 1'b0;
      if (hit) begin
        dt_o <= dt;
        case (kind)
          EVT_FS: begin
            sync_err_o   <= frame_open_q;
            frame_open_q <= 1'b1;
            crc_seen_q   <= 1'b0;
            line_o       <= '0;
          end
          EVT_FE: begin
            sync_err_o   <= ~frame_open_q;
            data_err_o   <= frame_open_q & crc_seen_q;
            frame_rcvd_o <= 1'b1;
            frame_open_q <= 1'b0;
            crc_seen_q   <= 1'b0;
          end
          EVT_LONG: begin
            line_o  <= line_o + LINE_W'(1);
            bytes_o <= wc;
            if (frame_open_q && crc_err) crc_seen_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vcfm_info_mux.sv
module vcfm_info_mux #(
  parameter int NUM_VC = 4,
  parameter int DT_W   = 6,
  parameter int WC_W   = 16,
  parameter int LINE_W = 16,
  parameter int INFO_W = 32,
  localparam int VC_W    = $clog2(NUM_VC),
  localparam int INFO1_W = LINE_W + WC_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [VC_W-1:0]               rd_sel,
  input  logic [NUM_VC-1:0][LINE_W-1:0] line_all,
  input  logic [NUM_VC-1:0][WC_W-1:0]   bytes_all,
  input  logic [NUM_VC-1:0][DT_W-1:0]   dt_all,
  output logic [INFO1_W-1:0]            info1,
  output logic [INFO_W-1:0]             info2
);
  localparam int PAD_W = INFO_W - DT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      info1 <= '0;
      info2 <= '0;
    end else begin
      info1 <= {line_all[rd_sel], bytes_all[rd_sel]};
      info2 <= {{PAD_W{1'b0}}, dt_all[rd_sel]};
    end
  end
endmodule

// File: rtl/vc_frame_monitor.sv
module vc_frame_monitor
  import vcfm_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int DT_W   = 6,
  parameter int WC_W   = 16,
  parameter int LINE_W = 16,
  parameter int INFO_W = 32,
  localparam int VC_W    = $clog2(NUM_VC),
  localparam int INFO1_W = LINE_W + WC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VC-1:0]  vc_enable,
  input  logic               evt_valid,
  input  logic [1:0]         evt_kind,
  input  logic [VC_W-1:0]    evt_vc,
  input  logic [DT_W-1:0]    evt_dt,
  input  logic [WC_W-1:0]    evt_wc,
  input  logic               evt_crc_err,
  input  logic [VC_W-1:0]    rd_vc,
  output logic [NUM_VC-1:0]  sync_err,
  output logic [NUM_VC-1:0]  data_err,
  output logic [NUM_VC-1:0]  frame_rcvd,
  output logic [INFO1_W-1:0] rd_info1,
  output logic [INFO_W-1:0]  rd_info2
);
  logic [NUM_VC-1:0]             hit;
  logic [NUM_VC-1:0][LINE_W-1:0] line_all;
  logic [NUM_VC-1:0][WC_W-1:0]   bytes_all;
  logic [NUM_VC-1:0][DT_W-1:0]   dt_all;
  evt_kind_e                     kind;

  assign kind = evt_kind_e'(evt_kind);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_ch
    assign hit[v] = evt_valid && vc_enable[v] && (evt_vc == VC_W'(v));

    vcfm_channel #(
      .DT_W  (DT_W),
      .WC_W  (WC_W),
      .LINE_W(LINE_W)
    ) ch_i (
      .clk         (clk),
      .rst         (rst),
      .hit         (hit[v]),
      .kind        (kind),
      .dt          (evt_dt),
      .wc          (evt_wc),
      .crc_err     (evt_crc_err),
      .sync_err_o  (sync_err[v]),
      .data_err_o  (data_err[v]),
      .frame_rcvd_o(frame_rcvd[v]),
      .line_o      (line_all[v]),
      .bytes_o     (bytes_all[v]),
      .dt_o        (dt_all[v])
    );
  end

  vcfm_info_mux #(
    .NUM_VC(NUM_VC),
    .DT_W  (DT_W),
    .WC_W  (WC_W),
    .LINE_W(LINE_W),
    .INFO_W(INFO_W)
  ) mux_i (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_vc),
    .line_all (line_all),
    .bytes_all(bytes_all),
    .dt_all   (dt_all),
    .info1    (rd_info1),
    .info2    (rd_info2)
  );
endmodule

// File: rtl/vcfm_checker.sv
module vcfm_checker #(
  parameter int NUM_VC = 4,
  localparam int VC_W = $clog2(NUM_VC)
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_VC-1:0] vc_enable,
  input logic              evt_valid,
  input logic [1:0]        evt_kind,
  input logic [VC_W-1:0]   evt_vc,
  input logic [NUM_VC-1:0] sync_err,
  input logic [NUM_VC-1:0] data_err,
  input logic [NUM_VC-1:0] frame_rcvd
);
  // R1: one event per cycle touches at most one channel
  assert_one_channel_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sync_err) && $onehot0(frame_rcvd) && $onehot0(data_err));

  // R10: no pulse without an event on the previous edge
  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(evt_valid) |-> (sync_err == '0 && data_err == '0 && frame_rcvd == '0));

  // R11: first cycle out of reset is quiet
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sync_err == '0 && data_err == '0 && frame_rcvd == '0));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    // R4: a data error only accompanies a frame end
    assert_data_err_at_fe_R4: assert property (@(posedge clk) disable iff (rst)
      data_err[v] |-> frame_rcvd[v]);

    // R5: frame received traces back to a frame end on this channel
    assert_rcvd_from_fe_R5: assert property (@(posedge clk) disable iff (rst)
      frame_rcvd[v] |-> $past(evt_valid && evt_kind == 2'd1 && evt_vc == VC_W'(v)));

    // R2: sync error traces back to a frame start or end on this channel
    assert_sync_from_frame_evt_R2: assert property (@(posedge clk) disable iff (rst)
      sync_err[v] |-> $past(evt_valid && evt_kind[1] == 1'b0 && evt_vc == VC_W'(v)));

    // R9: a masked channel never pulses
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (sync_err[v] || data_err[v] || frame_rcvd[v]) |-> $past(vc_enable[v]));
  end
endmodule

bind vc_frame_monitor vcfm_checker #(.NUM_VC(NUM_VC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .vc_enable (vc_enable),
  .evt_valid (evt_valid),
  .evt_kind  (evt_kind),
  .evt_vc    (evt_vc),
  .sync_err  (sync_err),
  .data_err  (data_err),
  .frame_rcvd(frame_rcvd)
);

// File: tb/vc_frame_monitor_tb_top.sv
module vc_frame_monitor_tb_top;
  localparam int K_FS = 0, K_FE = 1, K_LONG = 2, K_SHORT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  vc_enable = 4'hF;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_kind = '0;
  logic [1:0]  evt_vc = '0;
  logic [5:0]  evt_dt = '0;
  logic [15:0] evt_wc = '0;
  logic        evt_crc_err = 1'b0;
  logic [1:0]  rd_vc = '0;
  logic [3:0]  sync_err, data_err, frame_rcvd;
  logic [31:0] rd_info1, rd_info2;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vc_frame_monitor dut_i (
    .clk(clk), .rst(rst), .vc_enable(vc_enable), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_vc(evt_vc), .evt_dt(evt_dt), .evt_wc(evt_wc),
    .evt_crc_err(evt_crc_err), .rd_vc(rd_vc), .sync_err(sync_err),
    .data_err(data_err), .frame_rcvd(frame_rcvd), .rd_info1(rd_info1),
    .rd_info2(rd_info2)
  );

  // behavioural reference model
  int m_open [4];
  int m_crc  [4];
  int m_line [4];
  int m_bytes[4];
  int m_dt   [4];
  logic [3:0]  e_sync, e_data, e_rcvd;
  logic [31:0] e_info1, e_info2;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_open[i] = 0; m_crc[i] = 0; m_line[i] = 0; m_bytes[i] = 0; m_dt[i] = 0;
      end
      e_sync = 0; e_data = 0; e_rcvd = 0; e_info1 = 0; e_info2 = 0;
    end else begin
      int c;
      c = int'(rd_vc);
      e_info1 = (m_line[c] << 16) | m_bytes[c];
      e_info2 = m_dt[c];
      e_sync = 0; e_data = 0; e_rcvd = 0;
      c = int'(evt_vc);
      if (evt_valid && vc_enable[c]) begin
        m_dt[c] = int'(evt_dt);
        if (int'(evt_kind) == K_FS) begin
          if (m_open[c] != 0) e_sync[c] = 1'b1;
          m_open[c] = 1; m_crc[c] = 0; m_line[c] = 0;
        end else if (int'(evt_kind) == K_FE) begin
          if (m_open[c] == 0) e_sync[c] = 1'b1;
          if (m_open[c] != 0 && m_crc[c] != 0) e_data[c] = 1'b1;
          e_rcvd[c] = 1'b1;
          m_open[c] = 0; m_crc[c] = 0;
        end else if (int'(evt_kind) == K_LONG) begin
          m_line[c] = (m_line[c] + 1) % 65536;
          m_bytes[c] = int'(evt_wc);
          if (m_open[c] != 0 && evt_crc_err) m_crc[c] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks += 3;
      if (sync_err !== e_sync || data_err !== e_data || frame_rcvd !== e_rcvd) begin
        failures++;
        $display("FAIL R10/R2/R3/R4/R5 pulses act=%b/%b/%b exp=%b/%b/%b",
                 sync_err, data_err, frame_rcvd, e_sync, e_data, e_rcvd);
      end
      if (rd_info1 !== e_info1) begin
        failures++;
        $display("FAIL R6/R8 info1 act=%h exp=%h", rd_info1, e_info1);
      end
      if (rd_info2 !== e_info2) begin
        failures++;
        $display("FAIL R7 info2 act=%h exp=%h", rd_info2, e_info2);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int k, input int vc, input int dt, input int wc, input bit crc);
    evt_valid = 1'b1; evt_kind = 2'(k); evt_vc = 2'(vc);
    evt_dt = 6'(dt); evt_wc = 16'(wc); evt_crc_err = crc;
    @(negedge clk);
    evt_valid = 1'b0; evt_crc_err = 1'b0;
  endtask

  task automatic pulses(input string tag, input logic [3:0] s, input logic [3:0] d, input logic [3:0] r);
    chk({tag, " sync_err"}, {28'd0, sync_err}, {28'd0, s});
    chk({tag, " data_err"}, {28'd0, data_err}, {28'd0, d});
    chk({tag, " frame_rcvd"}, {28'd0, frame_rcvd}, {28'd0, r});
  endtask

  task automatic read(input int vc, output logic [31:0] w1, output logic [31:0] w2);
    rd_vc = 2'(vc);
    @(negedge clk);
    w1 = rd_info1; w2 = rd_info2;
  endtask

  initial begin
    logic [31:0] w1, w2;
    repeat (3) @(negedge clk);
    // R11 reset state
    pulses("R11 reset", 4'b0, 4'b0, 4'b0);
    chk("R11 info1 reset", rd_info1, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R6 R8 normal frame on VC0
    send(K_FS, 0, 6'h00, 0, 0);     pulses("R3 clean fs", 0, 0, 0);
    send(K_LONG, 0, 6'h2A, 100, 0);
    send(K_LONG, 0, 6'h2A, 200, 0);
    send(K_LONG, 0, 6'h2B, 300, 0);
    send(K_FE, 0, 6'h01, 0, 0);     pulses("R5 clean fe vc0", 0, 0, 4'b0001);
    read(0, w1, w2);
    chk("R6 info1 vc0", w1, {16'd3, 16'd300});
    chk("R7 info2 vc0", w2, 32'h01);

    // R2 unpaired frame end on VC1
    send(K_FE, 1, 6'h01, 0, 0);     pulses("R2 orphan fe", 4'b0010, 0, 4'b0010);

    // R3 double frame start on VC2
    send(K_FS, 2, 6'h00, 0, 0);
    send(K_LONG, 2, 6'h2A, 64, 0);
    send(K_FS, 2, 6'h00, 0, 0);     pulses("R3 double fs", 4'b0100, 0, 0);
    read(2, w1, w2);
    chk("R3 line restart", w1, {16'd0, 16'd64});
    send(K_FE, 2, 6'h01, 0, 0);     pulses("R3 fe after restart", 0, 0, 4'b0100);

    // R4 crc inside frame on VC3, then a clean frame
    send(K_FS, 3, 6'h00, 0, 0);
    send(K_LONG, 3, 6'h2A, 10, 1);
    send(K_LONG, 3, 6'h2A, 10, 0);
    send(K_FE, 3, 6'h01, 0, 0);     pulses("R4 crc frame", 0, 4'b1000, 4'b1000);
    send(K_FS, 3, 6'h00, 0, 0);
    send(K_LONG, 3, 6'h2A, 10, 0);
    send(K_FE, 3, 6'h01, 0, 0);     pulses("R4 history cleared", 0, 0, 4'b1000);
    // R4 crc outside frame ignored
    send(K_LONG, 0, 6'h2A, 5, 1);
    send(K_FS, 0, 6'h00, 0, 0);
    send(K_FE, 0, 6'h01, 0, 0);     pulses("R4 crc outside frame", 0, 0, 4'b0001);

    // R1 interleaved channels
    send(K_FS, 0, 6'h00, 0, 0);
    send(K_FS, 1, 6'h00, 0, 0);
    send(K_LONG, 1, 6'h2C, 7, 1);
    send(K_LONG, 0, 6'h2D, 9, 0);
    send(K_FE, 0, 6'h01, 0, 0);     pulses("R1 vc0 unaffected by vc1 crc", 0, 0, 4'b0001);
    send(K_FE, 1, 6'h01, 0, 0);     pulses("R1 vc1 crc frame", 0, 4'b0010, 4'b0010);
    read(0, w1, w2);
    chk("R1 vc0 info1", w1, {16'd1, 16'd9});

    // R7 short packet updates data type
    send(K_SHORT, 1, 6'h0A, 0, 0);  pulses("R7 short", 0, 0, 0);
    read(1, w1, w2);
    chk("R7 short dt", w2, 32'h0A);
    chk("R7 short keeps bytes", w1, {16'd1, 16'd7});

    // R9 masked channel
    vc_enable = 4'b1011;
    send(K_FE, 2, 6'h11, 0, 0);     pulses("R9 masked fe", 0, 0, 0);
    send(K_LONG, 2, 6'h12, 999, 1);
    send(K_FS, 2, 6'h13, 0, 0);     pulses("R9 masked fs", 0, 0, 0);
    read(2, w1, w2);
    chk("R9 masked info1", w1, {16'd0, 16'd64});
    chk("R9 masked info2", w2, 32'h01);
    vc_enable = 4'hF;
    send(K_FE, 2, 6'h01, 0, 0);     pulses("R9 no frame opened", 4'b0100, 0, 4'b0100);

    // R8 wrap of the line count
    send(K_FS, 1, 6'h00, 0, 0);
    for (int i = 0; i < 65537; i++) send(K_LONG, 1, 6'h2A, i % 65536, 0);
    read(1, w1, w2);
    chk("R8 line wrap", w1, {16'd1, 16'd0});
    send(K_FE, 1, 6'h01, 0, 0);     pulses("R10 single pulse", 0, 0, 4'b0010);
    @(negedge clk);                  pulses("R10 pulse ended", 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule